// File: doc/BRIEF.md
# Serial-Controlled Sign-Magnitude Current DAC Register Slave

This block is a two-wire serial slave that owns the control registers of a bank of current-DAC channels. It runs on a free-running system clock and oversamples the serial clock and data pins. The bus master can write one channel register per transaction. It can also read a register back by first setting the register pointer with a write and then issuing a repeated START with the read bit set. The serial data pad is open-drain. The block therefore never drives a high level on it and only asserts an output-enable that pulls the line low.

Each channel register holds a sign bit and a 7-bit magnitude. The block decodes every register into a source enable, a sink enable and a magnitude bus for the analog current cell next to it. Two strap inputs select one of four bus addresses, so four of these slaves can share one bus. The parameter `NCH` sets the bank to four channels or reduces it to two.

Top module: `cdac_i2c_ctrl`

## Requirements
- R1: The address byte is matched when its bit 7 equals `addr_sel_hi`, its bit 6 equals `addr_sel_lo`, bits 5:1 equal 10000b, and bit 0 is the read/write flag (0 write, 1 read). With both straps low, the write address byte is 20h. With both straps high, it is E0h. On a match, the slave pulls SDA low for the ninth (acknowledge) clock.
- R2: On an address byte that does not match, the slave does not acknowledge. It then leaves SDA released and ignores every later byte until the next START. No register changes.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START is handled exactly like a START, including during an ignored transfer. A write that is cut off by STOP or START before its data byte completes leaves every register unchanged.
- R4: A write is START, address byte (write), register byte, one data byte, STOP. When the register byte is F8h + n for an implemented channel n, the slave acknowledges all three bytes and stores the data in channel n. The channel outputs change while SCL is low after the eighth data bit, and never while SCL is high.
- R5: A read is a write of the register byte, then a repeated START and the address byte with bit 0 set. The slave then sends the register value MSB first and changes SDA only while SCL is low. The same register is sent again after each master acknowledge, with no auto-increment. After a master NACK, SDA is released.
- R6: In each register, bit 7 set selects source and bit 7 clear selects sink, and bits 6:0 are the magnitude on `mag_o`. A channel never asserts its source and sink enables together.
- R7: A magnitude of zero drives both enables low for either sign value.
- R8: After reset, every register is 00h, all enables and magnitudes are zero, and SDA is released.
- R9: A register byte outside F8h to F8h+NCH-1 is not acknowledged. The data byte that follows is not acknowledged and is discarded. A read that follows such a pointer returns 00h.
- R10: Only the first data byte of a write is stored. Every further data byte in the same transfer is not acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level (wired bus) |
| addr_sel_hi | input | 1 | Strap for address-byte bit 7 |
| addr_sel_lo | input | 1 | Strap for address-byte bit 6 |
| sda_oe | output | 1 | Pulls SDA low when high |
| src_en | output | NCH | Per-channel source enable |
| snk_en | output | NCH | Per-channel sink enable |
| mag_o | output | 7*NCH | Per-channel magnitude, channel n at bits 7n+6:7n |

## Verification
Two kinds of event can land in the same cycle. The first is recognising a START, which resets the framing, while the slave is already in the state that ignores a transfer whose address did not match. The bench provokes this by issuing a repeated START a few bits into the ignored transfer. It judges the result by checking that the write that follows is acknowledged and stored. The second is a STOP arriving in the middle of a data byte, just before the store would happen. Here the bench checks, on every clock, that the outputs still hold the earlier register value, and then reads that value back.

// File: rtl/cdac_pkg.sv
package cdac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_REG,
    ST_WDATA,
    ST_RDATA
  } link_st_t;

  localparam logic [7:0] REG_BASE   = 8'hF8;
  localparam logic [4:0] ADDR_FIXED = 5'b10000;
  localparam int         MAG_W      = 7;
  localparam int         CNT_W      = 4;
endpackage

// File: rtl/cdac_pin_sync.sv
module cdac_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/cdac_regbank.sv
module cdac_regbank import cdac_pkg::*; #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [IW-1:0]        rd_idx,
  input  logic                 rd_ok,
  output logic [7:0]           rd_data,
  output logic [NCH-1:0]       src_en,
  output logic [NCH-1:0]       snk_en,
  output logic [NCH*MAG_W-1:0] mag_o
);
  logic [7:0] regs_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic nz;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           regs_q[g] <= 8'h00;
      else if (wr_en && wr_idx == IW'(g))   regs_q[g] <= wr_data;
    end
    assign nz                    = |regs_q[g][MAG_W-1:0];
    assign mag_o[g*MAG_W +: MAG_W] = regs_q[g][MAG_W-1:0];
    assign src_en[g]             = regs_q[g][7] & nz;
    assign snk_en[g]             = ~regs_q[g][7] & nz;
  end

  assign rd_data = rd_ok ? regs_q[rd_idx] : 8'h00;
endmodule

// File: rtl/cdac_link_fsm.sv
module cdac_link_fsm import cdac_pkg::*; #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic [1:0]    strap,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [IW-1:0] ptr_o,
  output logic          ptr_ok_o,
  output logic [7:0]    wr_data
);
  link_st_t         st_q, st_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic [7:0]       sh_q, sh_d, tx_q, tx_d;
  logic             oe_q, oe_d, nack_q, nack_d, done_q, done_d;
  logic [IW-1:0]    ptr_q, ptr_d;
  logic             pok_q, pok_d;
  logic [7:0]       off;
  logic             in_rng, amatch;

  assign off    = sh_q - REG_BASE;
  assign in_rng = (sh_q >= REG_BASE) && (off < 8'(NCH));
  assign amatch = (sh_q[7:1] == {strap, ADDR_FIXED});

  always_comb begin
    st_d = st_q; bit_d = bit_q; sh_d = sh_q; tx_d = tx_q;
    oe_d = oe_q; nack_d = nack_q; done_d = done_q;
    ptr_d = ptr_q; pok_d = pok_q; wr_en = 1'b0;
    if (bus_stop) begin
      st_d = ST_IDLE; oe_d = 1'b0;
    end else if (bus_start) begin
      st_d = ST_ADDR; bit_d = '0; oe_d = 1'b0; done_d = 1'b0;
    end else if (st_q != ST_IDLE && scl_rise) begin
      if (bit_q < CNT_W'(8)) begin
        bit_d = bit_q + 1'b1;
        if (st_q != ST_RDATA) sh_d = {sh_q[6:0], sda_lvl};
      end else begin
        bit_d = CNT_W'(9);
        if (st_q == ST_RDATA) nack_d = sda_lvl;
      end
    end else if (st_q != ST_IDLE && scl_fall) begin
      if (st_q == ST_RDATA) begin
        if (bit_q == CNT_W'(9)) begin
          if (nack_q) begin
            st_d = ST_IDLE; oe_d = 1'b0;
          end else begin
            bit_d = '0; oe_d = ~rd_data[7]; tx_d = {rd_data[6:0], 1'b0};
          end
        end else if (bit_q == CNT_W'(8)) begin
          oe_d = 1'b0;
        end else if (bit_q != '0) begin
          oe_d = ~tx_q[7]; tx_d = {tx_q[6:0], 1'b0};
        end
      end else if (bit_q == CNT_W'(8)) begin
        case (st_q)
          ST_ADDR:  if (amatch) oe_d = 1'b1; else st_d = ST_IDLE;
          ST_REG: begin
            oe_d = in_rng; pok_d = in_rng; ptr_d = off[IW-1:0];
          end
          ST_WDATA: if (pok_q && !done_q) begin
            wr_en = 1'b1; oe_d = 1'b1; done_d = 1'b1;
          end
          default: ;
        endcase
      end else if (bit_q == CNT_W'(9)) begin
        oe_d = 1'b0; bit_d = '0;
        case (st_q)
          ST_ADDR: if (sh_q[0]) begin
            st_d = ST_RDATA; oe_d = ~rd_data[7]; tx_d = {rd_data[6:0], 1'b0};
          end else begin
            st_d = ST_REG;
          end
          ST_REG:  st_d = ST_WDATA;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; bit_q <= '0; sh_q <= '0; tx_q <= '0;
      oe_q <= 1'b0; nack_q <= 1'b0; done_q <= 1'b0;
      ptr_q <= '0; pok_q <= 1'b0;
    end else begin
      st_q <= st_d; bit_q <= bit_d; sh_q <= sh_d; tx_q <= tx_d;
      oe_q <= oe_d; nack_q <= nack_d; done_q <= done_d;
      ptr_q <= ptr_d; pok_q <= pok_d;
    end
  end

  assign sda_oe   = oe_q;
  assign ptr_o    = ptr_q;
  assign ptr_ok_o = pok_q;
  assign wr_data  = sh_q;
endmodule

// File: rtl/cdac_i2c_ctrl.sv
module cdac_i2c_ctrl import cdac_pkg::*; #(
  parameter int NCH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 addr_sel_hi,
  input  logic                 addr_sel_lo,
  output logic                 sda_oe,
  output logic [NCH-1:0]       src_en,
  output logic [NCH-1:0]       snk_en,
  output logic [NCH*MAG_W-1:0] mag_o
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [1:0]    rst_q;
  logic          rst_int_n;
  logic          scl_lvl, scl_rise, scl_fall;
  logic          sda_lvl, sda_rise, sda_fall;
  logic          wr_en, ptr_ok;
  logic [IW-1:0] ptr;
  logic [7:0]    wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  cdac_pin_sync #(.STAGES(2)) u_scl (
    .clk(clk), .rst_n(rst_int_n), .pin_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  cdac_pin_sync #(.STAGES(2)) u_sda (
    .clk(clk), .rst_n(rst_int_n), .pin_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  cdac_link_fsm #(.NCH(NCH), .IW(IW)) u_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
    .bus_start(sda_fall & scl_lvl), .bus_stop(sda_rise & scl_lvl),
    .strap({addr_sel_hi, addr_sel_lo}), .rd_data(rd_data),
    .sda_oe(sda_oe), .wr_en(wr_en), .ptr_o(ptr), .ptr_ok_o(ptr_ok),
    .wr_data(wr_data));

  cdac_regbank #(.NCH(NCH), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(wr_en), .wr_idx(ptr), .wr_data(wr_data),
    .rd_idx(ptr), .rd_ok(ptr_ok), .rd_data(rd_data),
    .src_en(src_en), .snk_en(snk_en), .mag_o(mag_o));
endmodule

// File: rtl/cdac_i2c_chk.sv
module cdac_i2c_chk #(
  parameter int NCH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_oe,
  input logic [NCH-1:0]     src_en,
  input logic [NCH-1:0]     snk_en,
  input logic [NCH*7-1:0]   mag_o
);
  logic rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= !rst_n;

  always @(posedge clk) begin
    if (!rst_n && rst_seen_q) begin
      assert_reset_idle_R8: assert (src_en == '0 && snk_en == '0 && mag_o == '0 && !sda_oe)
        else $error("reset state violated");
    end
  end

  assert_never_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en & snk_en) == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assert_zero_mag_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mag_o[g*7 +: 7] == 7'd0) |-> (!src_en[g] && !snk_en[g]));
    assert_nonzero_one_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mag_o[g*7 +: 7] != 7'd0) |-> $countones({src_en[g], snk_en[g]}) == 1);
  end

  assert_oe_rise_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
  assert_oe_fall_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_i);
  assert_hold_while_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> ($stable(mag_o) && $stable(src_en) && $stable(snk_en)));
endmodule

bind cdac_i2c_ctrl cdac_i2c_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .src_en(src_en), .snk_en(snk_en), .mag_o(mag_o));

// File: tb/tb_cdac_i2c_ctrl.sv
module tb_cdac_i2c_ctrl;
  localparam int NCH = 4;
  localparam int HP  = 10;
  localparam int QP  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic hi_s = 1'b0, lo_s = 1'b0;
  logic sda_oe, sda_bus;
  logic [NCH-1:0]   src_en, snk_en;
  logic [NCH*7-1:0] mag_o;

  int vecs = 0, miss = 0, settle = 0;
  bit done = 0, cmp_on = 0, prev_scl = 1'b1;
  logic [7:0] em [NCH];
  bit pend_on = 0; int pend_idx = 0; logic [7:0] pend_val = 8'h00;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  cdac_i2c_ctrl #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_hi(hi_s), .addr_sel_lo(lo_s), .sda_oe(sda_oe),
    .src_en(src_en), .snk_en(snk_en), .mag_o(mag_o));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vecs++;
    if (!ok) begin
      miss++;
      if (miss < 20) $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Per-clock reference comparison of the channel outputs (R4, R6, R7)
  always @(negedge clk) begin
    if (cmp_on) begin
      if (scl_m != prev_scl) settle = 8;
      else if (settle > 0) settle--;
      else begin
        for (int c = 0; c < NCH; c++) begin
          logic [6:0] m; bit s;
          m = em[c][6:0]; s = em[c][7];
          chk(mag_o[c*7 +: 7] == m, "R4 magnitude", mag_o[c*7 +: 7], m);
          chk(src_en[c] == (s && m != 0), "R6/R7 source enable", src_en[c], (s && m != 0));
          chk(snk_en[c] == (!s && m != 0), "R6/R7 sink enable", snk_en[c], (!s && m != 0));
        end
      end
      prev_scl = scl_m;
    end
  end

  task automatic cw(input int n); repeat (n) @(negedge clk); endtask

  task automatic do_start();
    sda_m = 1'b1; cw(QP); scl_m = 1'b1; cw(HP); sda_m = 1'b0; cw(HP); scl_m = 1'b0; cw(QP);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; cw(QP); scl_m = 1'b1; cw(HP); sda_m = 1'b1; cw(HP);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; cw(QP); scl_m = 1'b1; cw(HP); scl_m = 1'b0; cw(QP);
  endtask

  task automatic wr_byte(input logic [7:0] d, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    if (pend_on) begin em[pend_idx] = pend_val; pend_on = 0; end
    sda_m = 1'b1; cw(QP); scl_m = 1'b1; cw(QP);
    chk(sda_bus == !exp_ack, req, !sda_bus, exp_ack);
    cw(QP); scl_m = 1'b0; cw(QP);
  endtask

  task automatic rd_byte(input logic [7:0] expv, input bit mnack, input string req);
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; cw(QP); scl_m = 1'b1; cw(QP); got[i] = sda_bus; cw(QP); scl_m = 1'b0; cw(QP);
    end
    chk(got == expv, req, got, expv);
    send_bit(mnack);
  endtask

  function automatic bit addr_hit(input logic [7:0] a);
    return a[7:1] == {hi_s, lo_s, 5'b10000};
  endfunction

  function automatic bit reg_hit(input logic [7:0] r);
    return r >= 8'hF8 && r < 8'hF8 + NCH;
  endfunction

  task automatic wr_tail(input logic [7:0] a, input logic [7:0] r, input logic [7:0] d, input int extra);
    bit am, ok;
    am = addr_hit(a) && !a[0];
    ok = am && reg_hit(r);
    wr_byte(a, am, am ? "R1 address ack" : "R2 address nack");
    wr_byte(r, ok, am ? "R9 register byte ack" : "R2 ignored byte");
    if (ok) begin pend_on = 1; pend_idx = r - 8'hF8; pend_val = d; end
    wr_byte(d, ok, ok ? "R4 data ack" : "R9 data nack");
    for (int k = 0; k < extra; k++) wr_byte(d + 8'(k + 1), 1'b0, "R10 extra byte nack");
    do_stop();
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] r, input logic [7:0] d, input int extra);
    do_start(); wr_tail(a, r, d, extra);
  endtask

  task automatic rd_reg(input logic [7:0] r, input logic [7:0] expv);
    logic [7:0] wa;
    wa = {hi_s, lo_s, 6'b100000};
    do_start();
    wr_byte(wa, 1'b1, "R5 address ack");
    wr_byte(r, reg_hit(r), "R9 pointer ack");
    do_start();
    wr_byte(wa | 8'h01, 1'b1, "R5 read address ack");
    rd_byte(expv, 1'b0, "R5 read data");
    rd_byte(expv, 1'b1, "R5 repeat read no increment");
    chk(sda_oe == 1'b0, "R5 release after nack", sda_oe, 0);
    do_stop();
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) em[c] = 8'h00;
    cw(5);
    rst_n = 1'b1;
    cw(6);
    // R8: reset state
    chk(src_en == '0 && snk_en == '0, "R8 enables at reset", {src_en, snk_en}, 0);
    chk(mag_o == '0, "R8 magnitude at reset", mag_o, 0);
    chk(sda_oe == 1'b0, "R8 SDA released", sda_oe, 0);
    cmp_on = 1;

    wr_reg(8'h20, 8'hF8, 8'hAA, 0);          // R1 R4 R6: source 2Ah
    wr_reg(8'h20, 8'hF9, 8'h35, 0);          // R6 sink
    wr_reg(8'h20, 8'hFA, 8'h80, 0);          // R7 zero magnitude, source sign
    wr_reg(8'h20, 8'hFB, 8'h01, 0);          // R6 smallest sink
    rd_reg(8'hF8, 8'hAA);
    rd_reg(8'hF9, 8'h35);
    rd_reg(8'hFA, 8'h80);

    // R2 then R3: repeated START inside an ignored transfer
    do_start();
    wr_byte(8'h60, 1'b0, "R2 address nack");
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    do_start();
    wr_tail(8'h20, 8'hFB, 8'hFF, 0);
    rd_reg(8'hFB, 8'hFF);

    // R2: wrong address whole write ignored
    wr_reg(8'hA0, 8'hF8, 8'h11, 0);
    rd_reg(8'hF8, 8'hAA);

    // R9: out-of-range pointers
    wr_reg(8'h20, 8'hFC, 8'h42, 0);
    wr_reg(8'h20, 8'hF7, 8'h42, 0);
    rd_reg(8'hF7, 8'h00);

    // R10: extra data bytes discarded
    wr_reg(8'h20, 8'hF9, 8'h11, 2);
    rd_reg(8'hF9, 8'h11);

    // R3: STOP in the middle of the data byte
    do_start();
    wr_byte(8'h20, 1'b1, "R1 address ack");
    wr_byte(8'hF8, 1'b1, "R9 register byte ack");
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    do_stop();
    rd_reg(8'hF8, 8'hAA);

    // R1: straps both high select E0h; 20h is then ignored
    hi_s = 1'b1; lo_s = 1'b1;
    cw(10);
    wr_reg(8'hE0, 8'hFA, 8'h7F, 0);          // R6 source sign cleared -> sink 127
    wr_reg(8'h20, 8'hF8, 8'h55, 0);          // R2 not addressed
    rd_reg(8'hFA, 8'h7F);
    rd_reg(8'hF8, 8'hAA);

    cw(20);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule